// File: doc/BRIEF.md
# Byte-Coded Register Write Sequencer

This engine runs a short stored program of variable-length byte opcodes without host involvement. The host first loads the program as 32-bit words into a local program memory and then issues a start command. From then on the engine fetches one byte per clock and keeps an address register and a data register. It issues single-cycle writes on a simple register-bus master port, drives and releases a bank of 32 flag outputs, stalls on flag inputs, and inserts microsecond-scaled delays.

Each opcode byte is followed by a fixed number of operand bytes. Address and data operands can replace the full 32-bit value or only its lower half. The engine is used to replay timing-critical register sequences, such as a memory clock change, where the host is too slow or too far away to meet the spacing on its own. A busy status stays high for the whole run. An error status records that the engine stopped on an unknown opcode.

Top module: `regseq_engine`

## Requirements
- R1: After reset, busy, error, the bus write strobe, all flag outputs and all flag drive enables are 0.
- R2: Program word k holds program bytes 4k..4k+3, with the least significant byte first. A start pulse while idle makes busy high from the next cycle. Execution begins at byte 0, each fetched byte (opcode or operand) costs one cycle, and byte 0x7F ends the run: busy drops after the cycle that fetched it.
- R3: Opcode 0xE0 takes 4 operand bytes, least significant first, that replace the whole address register. In the cycle after the last operand byte, bus_we_o pulses for one cycle with the new address and the current data register.
- R4: Opcode 0x40 takes 2 operand bytes that replace only address bits 15:0, keeping bits 31:16, and then issues one bus write exactly as R3 does.
- R5: Opcode 0xE2 takes 4 operand bytes that load the whole data register, and opcode 0x42 takes 2 that load only bits 15:0. Neither issues a bus write.
- R6: Opcode 0x5F takes a flag index byte (bits 4:0 used) and a value byte (bit 0 used). The engine stays in a wait cycle until flags_i at that index equals the value, and then resumes on the next cycle.
- R7: Opcodes 0x80+i, 0xA0+i and 0xC0+i (i = 0..31) act on flag i. The first releases it (drive enable cleared). The second drives 0 and the third drives 1, both with the drive enable set.
- R8: Opcode 000sssmm waits mm*4^sss microseconds of CYC_PER_US clocks each. The opcode costs 2 + mm*4^sss*CYC_PER_US cycles of busy in total.
- R9: Any other opcode stops the run after its fetch cycle and sets err_o. err_o holds until the next start, which clears it.
- R10: A start pulse while busy is ignored and does not change the run length.
- R11: If no end byte is met, the run ends without error one cycle after the last byte of program memory has been fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_we_i | input | 1 | Program memory word write strobe |
| prog_addr_i | input | $clog2(PROG_WORDS) | Program memory word index |
| prog_wdata_i | input | 32 | Program word, byte 0 in bits 7:0 |
| start_i | input | 1 | Start command pulse |
| busy_o | output | 1 | Program running |
| err_o | output | 1 | Last run stopped on an undefined opcode |
| bus_we_o | output | 1 | Single-cycle register write strobe |
| bus_addr_o | output | 32 | Register write address |
| bus_wdata_o | output | 32 | Register write data |
| flags_i | input | 32 | Flags sampled by wait opcodes |
| flags_o | output | 32 | Driven flag values |
| flag_en_o | output | 32 | Flag drive enables |

## Verification
A byte-counter slip inside the fetch state machine shows up in the first run as a busy window of the wrong length. The same fault also makes later operands read as opcodes, which usually raises err_o or produces a bus write with a misassembled address within a few cycles. A wrong delay prescale or exponent changes the busy length by a multiple of CYC_PER_US on every delay opcode, so a sweep over the exponent and mantissa separates the two. A wrong flag decode leaves a flag output or enable different from the expected model after a single one-byte program.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int FLAG_W = 5;
  localparam int NFLAG  = 32;
  localparam int US_W   = 16;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_OPER, ST_WAIT, ST_DELAY} st_e;
  typedef enum logic [1:0] {OPK_ADDR, OPK_DATA, OPK_WAIT} opk_e;

  localparam logic [7:0] OPC_END    = 8'h7F;
  localparam logic [7:0] OPC_ADDR32 = 8'hE0;
  localparam logic [7:0] OPC_ADDR16 = 8'h40;
  localparam logic [7:0] OPC_DATA32 = 8'hE2;
  localparam logic [7:0] OPC_DATA16 = 8'h42;
  localparam logic [7:0] OPC_WAIT   = 8'h5F;

  // mantissa in [1:0], base-4 exponent in [4:2]
  function automatic logic [US_W-1:0] delay_us(input logic [4:0] code);
    return US_W'(code[1:0]) << (2 * code[4:2]);
  endfunction
endpackage

// File: rtl/regseq_progmem.sv
module regseq_progmem #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int BW    = AW + 2
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [BW-1:0] raddr_i,
  output logic [7:0]    rbyte_o
);
  logic [31:0] mem_q [DEPTH];
  logic [31:0] word;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign word    = mem_q[raddr_i[BW-1:2]];
  assign rbyte_o = word[8*raddr_i[1:0] +: 8];
endmodule

// File: rtl/regseq_delay.sv
module regseq_delay
  import regseq_pkg::*;
#(
  parameter int CYC_PER_US = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [US_W-1:0] us_i,
  output logic            active_o
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(CYC_PER_US - 1);

  logic [US_W-1:0] us_q;
  logic [PW-1:0]   pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q  <= '0;
      pre_q <= '0;
    end else if (load_i) begin
      us_q  <= us_i;
      pre_q <= PRE_MAX;
    end else if (us_q != '0) begin
      if (pre_q == '0) begin
        pre_q <= PRE_MAX;
        us_q  <= us_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign active_o = (us_q != '0);

  // R8
  delay_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && us_i != '0) |=> active_o);
  // R8
  delay_prescale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !load_i && pre_q != '0) |=> $stable(us_q));
endmodule

// File: rtl/regseq_core.sv
module regseq_core
  import regseq_pkg::*;
#(
  parameter int BW         = 9,
  parameter int CYC_PER_US = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       rbyte_i,
  output logic [BW-1:0]    raddr_o,
  input  logic [NFLAG-1:0] flags_i,
  output logic             busy_o,
  output logic             err_o,
  output logic             bus_we_o,
  output logic [31:0]      bus_addr_o,
  output logic [31:0]      bus_wdata_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] flag_en_o
);
  st_e              st_q;
  opk_e             opk_q;
  logic [BW:0]      pc_q;
  logic [1:0]       idx_q, last_q;
  logic [31:0]      addr_q, data_q;
  logic [FLAG_W-1:0] wait_idx_q;
  logic             wait_val_q, we_q, err_q;
  logic [NFLAG-1:0] fo_q, fe_q;
  logic             dly_load, dly_active;
  logic [US_W-1:0]  dly_us;

  assign dly_load = (st_q == ST_FETCH) && !pc_q[BW] && (rbyte_i[7:5] == 3'b000);
  assign dly_us   = delay_us(rbyte_i[4:0]);

  regseq_delay #(.CYC_PER_US(CYC_PER_US)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (dly_load),
    .us_i    (dly_us),
    .active_o(dly_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      opk_q      <= OPK_ADDR;
      pc_q       <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      wait_idx_q <= '0;
      wait_val_q <= 1'b0;
      we_q       <= 1'b0;
      err_q      <= 1'b0;
      fo_q       <= '0;
      fe_q       <= '0;
    end else begin
      we_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          pc_q  <= '0;
          err_q <= 1'b0;
          st_q  <= ST_FETCH;
        end
        ST_FETCH: begin
          if (pc_q[BW]) begin
            st_q <= ST_IDLE;  // ran off the end of memory
          end else begin
            pc_q  <= pc_q + 1'b1;
            idx_q <= '0;
            if (rbyte_i == OPC_END) begin
              st_q <= ST_IDLE;
            end else if (rbyte_i[7:5] == 3'b000) begin
              st_q <= ST_DELAY;
            end else if (rbyte_i == OPC_ADDR32 || rbyte_i == OPC_ADDR16) begin
              opk_q  <= OPK_ADDR;
              last_q <= rbyte_i[7] ? 2'd3 : 2'd1;
              st_q   <= ST_OPER;
            end else if (rbyte_i == OPC_DATA32 || rbyte_i == OPC_DATA16) begin
              opk_q  <= OPK_DATA;
              last_q <= rbyte_i[7] ? 2'd3 : 2'd1;
              st_q   <= ST_OPER;
            end else if (rbyte_i == OPC_WAIT) begin
              opk_q  <= OPK_WAIT;
              last_q <= 2'd1;
              st_q   <= ST_OPER;
            end else if (rbyte_i >= 8'h80 && rbyte_i < 8'hE0) begin
              unique case (rbyte_i[6:5])
                2'b00:   fe_q[rbyte_i[4:0]] <= 1'b0;
                2'b01:   begin fe_q[rbyte_i[4:0]] <= 1'b1; fo_q[rbyte_i[4:0]] <= 1'b0; end
                default: begin fe_q[rbyte_i[4:0]] <= 1'b1; fo_q[rbyte_i[4:0]] <= 1'b1; end
              endcase
            end else begin
              err_q <= 1'b1;
              st_q  <= ST_IDLE;
            end
          end
        end
        ST_OPER: begin
          pc_q  <= pc_q + 1'b1;
          idx_q <= idx_q + 1'b1;
          unique case (opk_q)
            OPK_ADDR: addr_q[8*idx_q +: 8] <= rbyte_i;
            OPK_DATA: data_q[8*idx_q +: 8] <= rbyte_i;
            default:  if (idx_q == 2'd0) wait_idx_q <= rbyte_i[FLAG_W-1:0];
                      else               wait_val_q <= rbyte_i[0];
          endcase
          if (idx_q == last_q) begin
            st_q <= (opk_q == OPK_WAIT) ? ST_WAIT : ST_FETCH;
            if (opk_q == OPK_ADDR) we_q <= 1'b1;
          end
        end
        ST_WAIT:  if (flags_i[wait_idx_q] == wait_val_q) st_q <= ST_FETCH;
        ST_DELAY: if (!dly_active) st_q <= ST_FETCH;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign raddr_o     = pc_q[BW-1:0];
  assign busy_o      = (st_q != ST_IDLE);
  assign err_o       = err_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = data_q;
  assign flags_o     = fo_q;
  assign flag_en_o   = fe_q;

  // R2
  busy_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R3
  we_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_we_o);
  // R6
  wait_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && flags_i[wait_idx_q] != wait_val_q) |=> st_q == ST_WAIT);
  // R9
  err_idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(err_o));
endmodule

// File: rtl/regseq_engine.sv
module regseq_engine
  import regseq_pkg::*;
#(
  parameter int PROG_WORDS = 128,
  parameter int CYC_PER_US = 4,
  parameter int AW         = $clog2(PROG_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_we_i,
  input  logic [AW-1:0]    prog_addr_i,
  input  logic [31:0]      prog_wdata_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             err_o,
  output logic             bus_we_o,
  output logic [31:0]      bus_addr_o,
  output logic [31:0]      bus_wdata_o,
  input  logic [NFLAG-1:0] flags_i,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] flag_en_o
);
  localparam int BW = AW + 2;

  logic [BW-1:0] raddr;
  logic [7:0]    rbyte;

  regseq_progmem #(.DEPTH(PROG_WORDS), .AW(AW), .BW(BW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (prog_we_i),
    .waddr_i(prog_addr_i),
    .wdata_i(prog_wdata_i),
    .raddr_i(raddr),
    .rbyte_o(rbyte)
  );

  regseq_core #(.BW(BW), .CYC_PER_US(CYC_PER_US)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rbyte_i    (rbyte),
    .raddr_o    (raddr),
    .flags_i    (flags_i),
    .busy_o     (busy_o),
    .err_o      (err_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .flags_o    (flags_o),
    .flag_en_o  (flag_en_o)
  );
endmodule

// File: tb/regseq_engine_tb.sv
module regseq_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 64;
  localparam int CPU        = 3;
  localparam int AW         = $clog2(WORDS);

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        prog_we = 1'b0, start = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [31:0] prog_wdata = '0;
  logic        busy, err, bus_we;
  logic [31:0] bus_addr, bus_wdata, flags_in = '0, flags_out, flag_en;

  int nchk = 0, nfail = 0;
  logic [7:0]  pb [256];
  int plen;
  logic [31:0] wa [256], wd [256];
  int nw = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regseq_engine #(.PROG_WORDS(WORDS), .CYC_PER_US(CPU)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_we_i(prog_we), .prog_addr_i(prog_addr),
    .prog_wdata_i(prog_wdata), .start_i(start), .busy_o(busy), .err_o(err),
    .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .flags_i(flags_in), .flags_o(flags_out), .flag_en_o(flag_en));

  always @(negedge clk) if (bus_we && nw < 256) begin
    wa[nw] = bus_addr; wd[nw] = bus_wdata; nw++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    pb[plen] = b; plen++;
  endtask

  task automatic load_prog();
    while (plen % 4 != 0) put(8'h7F);
    for (int w = 0; w < plen / 4; w++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = AW'(w);
      prog_wdata = {pb[4*w+3], pb[4*w+2], pb[4*w+1], pb[4*w]};
    end
    @(negedge clk) prog_we = 1'b0;
  endtask

  task automatic run(input int mid, output int cyc);
    load_prog();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (busy && cyc < 100000) begin
      cyc++;
      @(negedge clk);
      start = (cyc == mid);
    end
    start = 1'b0;
  endtask

  function automatic bit undefined_op(input int b);
    if (b < 8'h20) return 0;
    if (b == 8'h40 || b == 8'h42 || b == 8'h5F || b == 8'h7F) return 0;
    if (b >= 8'h80 && b < 8'hE0) return 0;
    if (b == 8'hE0 || b == 8'hE2) return 0;
    return 1;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int cyc, base;
    logic [31:0] a, d, exp_o, exp_e;
    logic [15:0] al, dl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !err && !bus_we, "R1", "status after reset", {busy, err, bus_we}, 0);
    check(flags_out == 0 && flag_en == 0, "R1", "flags after reset", flags_out | flag_en, 0);

    // R2 R3 R4 R5: full and half address/data updates
    a = 32'h1234_5678; d = 32'h9ABC_DEF0;
    for (int it = 0; it < 8; it++) begin
      a = a * 32'd1664525 + 32'd1013904223;
      d = d * 32'd22695477 + 32'd1;
      al = a[31:16] ^ 16'h5A5A; dl = d[31:16] ^ 16'hC3C3;
      plen = 0;
      put(8'hE2); for (int k = 0; k < 4; k++) put(d[8*k +: 8]);
      put(8'hE0); for (int k = 0; k < 4; k++) put(a[8*k +: 8]);
      put(8'h42); put(dl[7:0]); put(dl[15:8]);
      put(8'h40); put(al[7:0]); put(al[15:8]);
      put(8'h7F);
      base = nw;
      run(-1, cyc);
      check(cyc == 17, "R2", "busy cycles", cyc, 17);
      check(nw - base == 2, "R3", "write count", nw - base, 2);
      check(wa[base] == a && wd[base] == d, "R3", "full write addr", wa[base], a);
      check(wa[base+1] == {a[31:16], al}, "R4", "half addr", wa[base+1], {a[31:16], al});
      check(wd[base+1] == {d[31:16], dl}, "R5", "half data", wd[base+1], {d[31:16], dl});
    end
    plen = 0;
    put(8'hE2); put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    put(8'h42); put(8'h55); put(8'h66); put(8'h7F);
    base = nw;
    run(-1, cyc);
    check(nw == base, "R5", "data ops write nothing", nw - base, 0);
    check(cyc == 9, "R5", "data-only busy cycles", cyc, 9);

    // R8 delay sweep
    for (int s = 0; s < 5; s++) begin
      for (int m = 0; m < 4; m++) begin
        int n;
        n = m * (1 << (2 * s));
        plen = 0; put(8'((s << 2) | m)); put(8'h7F);
        run(-1, cyc);
        check(cyc == n * CPU + 3, "R8", $sformatf("delay s=%0d m=%0d", s, m), cyc, n * CPU + 3);
      end
    end

    // R7 flag set / drive / release sweep
    exp_o = '0; exp_e = '0;
    for (int i = 0; i < 32; i++) begin
      for (int t = 2; t >= 0; t--) begin
        plen = 0; put(8'(8'h80 + 32 * t + i)); put(8'h7F);
        run(-1, cyc);
        if (t == 0) exp_e[i] = 1'b0;
        else begin exp_e[i] = 1'b1; exp_o[i] = (t == 2); end
        check(flags_out == exp_o, "R7", $sformatf("flags_o i=%0d t=%0d", i, t), flags_out, exp_o);
        check(flag_en == exp_e, "R7", $sformatf("flag_en i=%0d t=%0d", i, t), flag_en, exp_e);
      end
    end

    // R6 wait on flag
    flags_in = '0;
    plen = 0; put(8'h5F); put(8'h07); put(8'h01); put(8'h7F);
    load_prog();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    check(busy, "R6", "stalled on flag", busy, 1);
    flags_in[7] = 1'b1;
    @(negedge clk);
    check(busy, "R6", "resume cycle busy", busy, 1);
    @(negedge clk);
    check(!busy, "R6", "ends after match", busy, 0);
    flags_in = '0;
    plen = 0; put(8'h5F); put(8'h03); put(8'h00); put(8'h7F);
    run(-1, cyc);
    check(cyc == 5, "R6", "already-equal wait", cyc, 5);

    // R9 undefined opcodes
    for (int b = 0; b < 256; b++) begin
      if (undefined_op(b)) begin
        plen = 0; put(8'(b)); put(8'h7F);
        run(-1, cyc);
        check(err && cyc == 1, "R9", $sformatf("undefined %0h", b), {err, 8'(cyc)}, {1'b1, 8'd1});
      end
    end
    plen = 0; put(8'h7F);
    run(-1, cyc);
    check(!err && cyc == 1, "R9", "start clears error", err, 0);

    // R10 start during run ignored
    plen = 0; put(8'h0B); put(8'h7F);
    run(10, cyc);
    check(cyc == 48 * CPU + 3, "R10", "mid-run start", cyc, 48 * CPU + 3);

    // R11 run past end of memory
    plen = 0;
    for (int k = 0; k < WORDS * 4; k++) put(8'hA5);
    run(-1, cyc);
    check(cyc == WORDS * 4 + 1 && !err, "R11", "end of memory", cyc, WORDS * 4 + 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule